// File: doc/BRIEF.md
# GPIO Port Register Bank

A 32-pin general-purpose I/O port with a small memory-mapped register file. Software sets each pin's direction, its output level, a per-pin blink enable and a per-pin input polarity through a simple 32-bit read/write bus addressed by byte offset. The block drives the pad output enables and output values and returns a data-in word in which every synchronized pin level is XORed with its polarity bit, so that active-low lines read as active-high.

Pins configured as outputs follow their output-level bit, unless their blink bit is set. In that case they follow a shared blink phase, which a prescaler counter toggles every `BLINK_DIV` clock cycles. The polarity-corrected data-in vector is also exported on its own port for downstream interrupt logic. A pin that is not used is left as an output that drives low.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset the direction register reads all ones (every pin an input). The output-level, blink-enable and polarity registers read 0. `pin_oe` and `pin_out` are all zero.
- R2: Writes land at byte offsets 0x00 (output level), 0x04 (direction, 1 = input), 0x08 (blink enable) and 0x0C (input polarity). A read with `rd_en` returns the addressed register on `rdata` after the next rising clock edge.
- R3: `pin_oe[i]` is 1 exactly when direction bit i is 0.
- R4: An output pin whose blink bit is 0 drives its output-level bit. An input pin drives `pin_out[i]` = 0. An unused pin (direction 0, level 0) is an enabled output that drives low.
- R5: Offset 0x10 reads, and `din_vec` carries, each pin level after a two-flop synchronizer XOR its polarity bit. A pin change shows on `din_vec` after two rising edges.
- R6: A write to 0x10 or to any unmapped offset changes no register. A read of an unmapped offset returns 0.
- R7: Every output pin with its blink bit set drives the same blink phase, and that phase toggles once every `BLINK_DIV` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Raw pad input levels |
| pin_out | output | 32 | Pad output values |
| pin_oe | output | 32 | Pad output enables |
| din_vec | output | 32 | Polarity-corrected synchronized inputs |

## Verification
The data-in path is tried with several pin patterns under all-zero, all-one and mixed polarity masks. This separates a missing XOR, an inverted XOR and a wrong bit mapping. Output driving is exercised with mixed direction and level words, which tells apart an output enable of the wrong sense from a level that is not masked on input pins. Blinking is checked by counting toggles over a fixed window on two pins and comparing them every cycle, which catches a wrong divider and pins drifting out of phase. Writes to the read-only and unmapped offsets are followed by reads of every register.

// File: rtl/gpio_port_bank.sv
module gpio_port_bank #(
  parameter int NPINS     = 32,
  parameter int AW        = 5,
  parameter int BLINK_DIV = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic [NPINS-1:0] din_vec
);
  localparam int CW = (BLINK_DIV > 1) ? $clog2(BLINK_DIV) : 1;
  localparam logic [AW-1:0] OFS_LVL = AW'(8'h00);
  localparam logic [AW-1:0] OFS_DIR = AW'(8'h04);
  localparam logic [AW-1:0] OFS_BLK = AW'(8'h08);
  localparam logic [AW-1:0] OFS_POL = AW'(8'h0C);
  localparam logic [AW-1:0] OFS_DIN = AW'(8'h10);

  logic [NPINS-1:0] lvl_q, dir_q, blk_q, pol_q;
  logic [NPINS-1:0] sync1_q, sync2_q;
  logic [CW-1:0]    div_q;
  logic             phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      dir_q <= '1;
      blk_q <= '0;
      pol_q <= '0;
    end else if (wr_en) begin
      case (addr)
        OFS_LVL: lvl_q <= wdata;
        OFS_DIR: dir_q <= wdata;
        OFS_BLK: blk_q <= wdata;
        OFS_POL: pol_q <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      phase_q <= 1'b0;
    end else if (div_q == CW'(BLINK_DIV - 1)) begin
      div_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign din_vec = sync2_q ^ pol_q;
  assign pin_oe  = ~dir_q;
  assign pin_out = ~dir_q & ((blk_q & {NPINS{phase_q}}) | (~blk_q & lvl_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        OFS_LVL: rdata <= lvl_q;
        OFS_DIR: rdata <= dir_q;
        OFS_BLK: rdata <= blk_q;
        OFS_POL: rdata <= pol_q;
        OFS_DIN: rdata <= din_vec;
        default: rdata <= '0;
      endcase
    end
  end
endmodule

module gpio_port_bank_chk #(
  parameter int NPINS = 32,
  parameter int AW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [AW-1:0]    addr,
  input logic [NPINS-1:0] wdata,
  input logic [NPINS-1:0] pin_in,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe,
  input logic [NPINS-1:0] din_vec,
  input logic [NPINS-1:0] pol_q,
  input logic [NPINS-1:0] blk_q
);
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 1'b1;
  end

  logic [NPINS-1:0] blinking;
  assign blinking = blk_q & pin_oe;

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> (pin_oe == '0 && pin_out == '0));

  // R3
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(8'h04)) |=> pin_oe == ~$past(wdata));

  // R6
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(8'h10)) |=> ($stable(pin_oe) && $stable(din_vec ^ pol_q)));

  // R5
  sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> din_vec == ($past(pin_in, 2) ^ pol_q));

  // R4
  in_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);

  // R7
  blink_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out & blinking) == '0) || ((pin_out & blinking) == blinking));
endmodule

bind gpio_port_bank gpio_port_bank_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .din_vec(din_vec),
  .pol_q(pol_q), .blk_q(blk_q)
);

// File: tb/gpio_port_bank_test.sv
module gpio_port_bank_test;
  localparam int PER = 10;
  localparam int DIV = 8;

  logic        clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, pin_in = '0;
  logic [31:0] rdata, pin_out, pin_oe, din_vec;

  int checks = 0, failures = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(PER/2) clk = ~clk;

  gpio_port_bank #(.BLINK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .din_vec(din_vec));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [4:0] a, logic [31:0] exp, string tag);
    @(negedge clk); rd_en = 1; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd_en = 0;
  endtask

  initial forever begin
    @(posedge clk);
    if (rd_en) begin
      @(negedge clk);
      if (exp_q.size() == 0) check("monitor underflow", 32'h1, 32'h0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(PER * 100000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic prev;
    int   toggles;
    #(PER * 3); @(negedge clk);
    check("R1 oe", pin_oe, 32'h0);
    check("R1 out", pin_out, 32'h0);
    rst_n = 1;
    rd(5'h04, 32'hFFFF_FFFF, "R1 dir");
    rd(5'h00, 32'h0, "R1 lvl");
    rd(5'h08, 32'h0, "R1 blk");
    rd(5'h0C, 32'h0, "R1 pol");

    wr(5'h00, 32'hA5A5_0F0F);
    wr(5'h0C, 32'h1234_5678);
    rd(5'h00, 32'hA5A5_0F0F, "R2 lvl");
    rd(5'h0C, 32'h1234_5678, "R2 pol");

    wr(5'h04, 32'hFFFF_0000);
    @(negedge clk);
    check("R3 oe", pin_oe, 32'h0000_FFFF);
    check("R4 out", pin_out, 32'h0000_0F0F);
    wr(5'h00, 32'h0000_0000);
    check("R4 unused low", pin_out & 32'h0000_FFFF, 32'h0);

    pin_in = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    rd(5'h10, 32'hDEAD_BEEF ^ 32'h1234_5678, "R5 din mixed pol");
    check("R5 vec", din_vec, 32'hDEAD_BEEF ^ 32'h1234_5678);
    wr(5'h0C, 32'hFFFF_FFFF);
    rd(5'h10, ~32'hDEAD_BEEF, "R5 din all pol");
    wr(5'h0C, 32'h0);
    @(negedge clk); pin_in = 32'h0000_0001;
    @(negedge clk); check("R5 sync 1 edge", din_vec, 32'hDEAD_BEEF);
    @(negedge clk); check("R5 sync 2 edge", din_vec, 32'h0000_0001);

    wr(5'h10, 32'h5555_5555);
    wr(5'h14, 32'h5555_5555);
    wr(5'h1C, 32'h5555_5555);
    rd(5'h00, 32'h0, "R6 lvl kept");
    rd(5'h04, 32'hFFFF_0000, "R6 dir kept");
    rd(5'h08, 32'h0, "R6 blk kept");
    rd(5'h0C, 32'h0, "R6 pol kept");
    rd(5'h14, 32'h0, "R6 unmapped read");
    rd(5'h10, 32'h0000_0001, "R6 din kept");

    wr(5'h00, 32'h0000_0100);
    wr(5'h08, 32'h0000_0028);
    @(negedge clk);
    prev = pin_out[3]; toggles = 0;
    for (int i = 0; i < 4 * DIV; i++) begin
      @(negedge clk);
      if (pin_out[3] != prev) toggles++;
      prev = pin_out[3];
      if (pin_out[5] !== pin_out[3]) check("R7 in phase", 32'(pin_out[5]), 32'(pin_out[3]));
    end
    check("R7 toggles", 32'(toggles), 32'd4);
    check("R7 steady pin8", 32'(pin_out[8]), 32'd1);

    wr(5'h04, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R4 inputs quiet", pin_out, 32'h0);

    repeat (3) @(negedge clk);
    check("monitor drained", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule